// File: doc/BRIEF.md
# PLL Configuration and Lock-Status Controller

This block holds the configuration of two PLL channels and reports when each is ready for use. The main channel takes a multiplier and a pre-divider. The secondary channel has a fixed ratio and is turned on with an enable bit and a bias bit. The analog PLLs are not modelled. Lock is emulated by a countdown that runs on a slow reference clock. The countdown restarts on every configuration write to its channel and ends after a programmed number of slow-clock cycles.

Software writes the configuration over a plain bus with address, write data, write strobe and combinational read data. It then polls the status word or waits for the interrupt. Each configuration write crosses into the slow-clock domain through a toggle synchronizer. The lock flags and the write acknowledge come back through two-flop synchronizers. A channel's lock flag reads low from the bus cycle after a write to that channel until the acknowledged new countdown has expired.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, every configuration field, both lock flags, the interrupt mask and `irq` are 0.
- R2: A single write to address 0 loads the main channel fields: divider bits [7:0], multiplier bits [15:8], lock count bits [21:16] and output range bits [25:24]. The same layout reads back at address 0.
- R3: The main channel is enabled only when the multiplier is non-zero. `main_factor` is the multiplier plus one when the channel is enabled and 0 otherwise. `main_div_en` is high only when the divider is non-zero.
- R4: After a write to the main channel with lock count N, the main lock flag stays low for at least N slow-clock cycles. It is high within N+8 slow-clock cycles plus four bus cycles.
- R5: Any write to address 0, including one that changes the multiplier or divider, drives the main lock flag low from the next bus cycle until the new countdown has expired.
- R6: While a channel is disabled, its lock flag is low and its countdown is held in reset.
- R7: Address 1 holds the secondary channel: enable at bit 0, bias at bit 1, lock count at bits [13:8]. `aux_pll_en` is high only when both the enable and bias bits are set. The lock flag then follows the same count rule as R4.
- R8: Writing ones to address 3 sets interrupt mask bits, and writing ones to address 4 clears them. The mask reads back at address 5, with bit 0 for the main channel and bit 1 for the secondary channel. `irq` is the OR of (lock flag AND mask bit) over both channels.
- R9: A lock count of 0 makes the lock flag rise on the first slow-clock edge after the synchronized write is seen. It is readable within five slow-clock cycles plus four bus cycles.
- R10: Address 2 returns the main lock flag at bit 0 and the secondary lock flag at bit 1. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sclk | input | 1 | Slow reference clock for the lock countdowns |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| addr | input | AW (3) | Word address |
| wdata | input | DW (32) | Write data |
| we | input | 1 | Write strobe, one bus cycle per write |
| rdata | output | DW (32) | Combinational read data |
| irq | output | 1 | Interrupt, level |
| main_pll_en | output | 1 | Main channel enabled |
| main_div | output | 8 | Main pre-divider value |
| main_div_en | output | 1 | Pre-divider active |
| main_mul | output | 8 | Main multiplier field |
| main_factor | output | 9 | Effective multiplication factor |
| main_range | output | 2 | Output range field |
| aux_pll_en | output | 1 | Secondary channel enabled |
| aux_bias_en | output | 1 | Secondary bias enable |
| lock_main | output | 1 | Main lock flag, bus domain |
| lock_aux | output | 1 | Secondary lock flag, bus domain |

## Verification
Lock timing is tested with a non-zero count, a zero count and a rewrite of an already locked channel. The non-zero count separates a countdown that is too short from one that never ends. The zero count exposes an off-by-one at the start edge. The rewrite checks that stale lock is masked at once. Disabled configurations are tried: a zero multiplier, and an enable bit without its bias bit. These show that the enable decode forces the flag low rather than only gating the outputs. Interrupt tests set and clear mask bits while one channel is locked and the other is not, which shows whether the mask and the flags are combined per channel.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int NCH      = 2;
  localparam int CH_MAIN  = 0;
  localparam int CH_AUX   = 1;

  localparam int DIV_W    = 8;
  localparam int MUL_W    = 8;
  localparam int CNT_W    = 6;
  localparam int RNG_W    = 2;

  localparam int DIV_LSB  = 0;
  localparam int MUL_LSB  = 8;
  localparam int CNT_LSB  = 16;
  localparam int RNG_LSB  = 24;

  localparam int AUX_EN_BIT   = 0;
  localparam int AUX_BIAS_BIT = 1;
  localparam int AUX_CNT_LSB  = 8;

  localparam int ADDR_W   = 3;
  localparam int A_MAIN   = 0;
  localparam int A_AUX    = 1;
  localparam int A_STAT   = 2;
  localparam int A_ISET   = 3;
  localparam int A_ICLR   = 4;
  localparam int A_IMSK   = 5;

  // main channel runs only with a non-zero multiplier
  function automatic logic main_on(input logic [MUL_W-1:0] m);
    return (m != '0);
  endfunction

  // effective multiplication factor, 0 when the channel is off
  function automatic logic [MUL_W:0] mult_factor(input logic [MUL_W-1:0] m);
    return main_on(m) ? ({1'b0, m} + (MUL_W+1)'(1)) : '0;
  endfunction

  function automatic logic aux_on(input logic en, input logic bias);
    return en & bias;
  endfunction
endpackage

// File: rtl/pllc_sync2.sv
module pllc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer
  import pllc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          req_tog,
  input  logic          enable,
  input  logic [CW-1:0] count,
  output logic          locked,
  output logic          ack_tog
);
  logic          req_s;
  logic          req_d;
  logic          start;
  logic [CW-1:0] remaining;

  pllc_sync2 #(.W(1)) u_req_sync (
    .clk  (sclk),
    .rst_n(rst_n),
    .d    (req_tog),
    .q    (req_s)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_s;
  end

  assign start   = req_s ^ req_d;
  assign ack_tog = req_d;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      locked    <= 1'b0;
    end else if (!enable) begin
      remaining <= '0;
      locked    <= 1'b0;
    end else if (start) begin
      remaining <= count;
      locked    <= (count == '0);
    end else if (!locked && remaining != '0) begin
      remaining <= remaining - CW'(1);
      if (remaining == CW'(1)) locked <= 1'b1;
    end
  end

  p_restart_clears_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    (start && enable && count != '0) |=> !locked);

  p_zero_count_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    (start && enable && count == '0) |=> locked);

  p_disabled_low_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    !enable |=> (!locked && remaining == '0));
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pllc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              sclk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  output logic [DW-1:0]     rdata,
  output logic              irq,
  output logic              main_pll_en,
  output logic [DIV_W-1:0]  main_div,
  output logic              main_div_en,
  output logic [MUL_W-1:0]  main_mul,
  output logic [MUL_W:0]    main_factor,
  output logic [RNG_W-1:0]  main_range,
  output logic              aux_pll_en,
  output logic              aux_bias_en,
  output logic              lock_main,
  output logic              lock_aux
);
  logic [CNT_W-1:0] main_cnt;
  logic [CNT_W-1:0] aux_cnt;
  logic             aux_en_q;
  logic             aux_bias_q;
  logic [NCH-1:0]   imask;
  logic [NCH-1:0]   req_tog;
  logic [NCH-1:0]   chan_en;
  logic [CNT_W-1:0] chan_cnt [NCH];
  logic [NCH-1:0]   lk_raw;
  logic [NCH-1:0]   ack_raw;
  logic [NCH-1:0]   lk_s;
  logic [NCH-1:0]   ack_s;
  logic [NCH-1:0]   pending;
  logic [NCH-1:0]   status;
  logic             wr_main;
  logic             wr_aux;
  logic             wr_iset;
  logic             wr_iclr;

  assign wr_main = we && (addr == AW'(A_MAIN));
  assign wr_aux  = we && (addr == AW'(A_AUX));
  assign wr_iset = we && (addr == AW'(A_ISET));
  assign wr_iclr = we && (addr == AW'(A_ICLR));

  // configuration registers, bus domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_div   <= '0;
      main_mul   <= '0;
      main_cnt   <= '0;
      main_range <= '0;
      aux_en_q   <= 1'b0;
      aux_bias_q <= 1'b0;
      aux_cnt    <= '0;
    end else begin
      if (wr_main) begin
        main_div   <= wdata[DIV_LSB +: DIV_W];
        main_mul   <= wdata[MUL_LSB +: MUL_W];
        main_cnt   <= wdata[CNT_LSB +: CNT_W];
        main_range <= wdata[RNG_LSB +: RNG_W];
      end
      if (wr_aux) begin
        aux_en_q   <= wdata[AUX_EN_BIT];
        aux_bias_q <= wdata[AUX_BIAS_BIT];
        aux_cnt    <= wdata[AUX_CNT_LSB +: CNT_W];
      end
    end
  end

  // interrupt mask: set and clear through separate addresses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imask <= '0;
    else if (wr_iset) imask <= imask | wdata[NCH-1:0];
    else if (wr_iclr) imask <= imask & ~wdata[NCH-1:0];
  end

  // one toggle per configuration write, per channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_tog <= '0;
    else begin
      if (wr_main) req_tog[CH_MAIN] <= ~req_tog[CH_MAIN];
      if (wr_aux)  req_tog[CH_AUX]  <= ~req_tog[CH_AUX];
    end
  end

  assign chan_en[CH_MAIN]  = main_on(main_mul);
  assign chan_en[CH_AUX]   = aux_on(aux_en_q, aux_bias_q);
  assign chan_cnt[CH_MAIN] = main_cnt;
  assign chan_cnt[CH_AUX]  = aux_cnt;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pllc_lock_timer #(.CW(CNT_W)) u_tmr (
      .sclk   (sclk),
      .rst_n  (rst_n),
      .req_tog(req_tog[c]),
      .enable (chan_en[c]),
      .count  (chan_cnt[c]),
      .locked (lk_raw[c]),
      .ack_tog(ack_raw[c])
    );
  end

  pllc_sync2 #(.W(NCH)) u_lock_sync (
    .clk(clk), .rst_n(rst_n), .d(lk_raw), .q(lk_s)
  );
  pllc_sync2 #(.W(NCH)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_raw), .q(ack_s)
  );

  // a write not yet acknowledged hides any stale lock
  assign pending = req_tog ^ ack_s;
  assign status  = lk_s & ~pending & chan_en;

  assign lock_main   = status[CH_MAIN];
  assign lock_aux    = status[CH_AUX];
  assign irq         = |(status & imask);
  assign main_pll_en = chan_en[CH_MAIN];
  assign main_div_en = (main_div != '0);
  assign main_factor = mult_factor(main_mul);
  assign aux_pll_en  = chan_en[CH_AUX];
  assign aux_bias_en = aux_bias_q;

  always_comb begin
    rdata = '0;
    case (int'(addr))
      A_MAIN: begin
        rdata[DIV_LSB +: DIV_W] = main_div;
        rdata[MUL_LSB +: MUL_W] = main_mul;
        rdata[CNT_LSB +: CNT_W] = main_cnt;
        rdata[RNG_LSB +: RNG_W] = main_range;
      end
      A_AUX: begin
        rdata[AUX_EN_BIT]             = aux_en_q;
        rdata[AUX_BIAS_BIT]           = aux_bias_q;
        rdata[AUX_CNT_LSB +: CNT_W]   = aux_cnt;
      end
      A_STAT:  rdata[NCH-1:0] = status;
      A_IMSK:  rdata[NCH-1:0] = imask;
      default: rdata = '0;
    endcase
  end

  p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main |=> !lock_main);

  p_main_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_mul == '0) |-> !lock_main);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (lock_main || lock_aux));

  p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iclr && !wr_iset && wdata[CH_MAIN]) |=> !imask[CH_MAIN]);

  p_factor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    main_pll_en |-> (main_factor > 9'd1));
endmodule

// File: tb/pll_lock_ctrl_tb.sv
module pll_lock_ctrl_tb;
  logic        clk = 0;
  logic        sclk = 0;
  logic        rst_n = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 0;
  logic [31:0] rdata;
  logic        irq, main_pll_en, main_div_en, aux_pll_en, aux_bias_en;
  logic [7:0]  main_div, main_mul;
  logic [8:0]  main_factor;
  logic [1:0]  main_range;
  logic        lock_main, lock_aux;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5  clk  = ~clk;
  always #35 sclk = ~sclk;

  pll_lock_ctrl u_dut (
    .clk(clk), .sclk(sclk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .we(we), .rdata(rdata), .irq(irq), .main_pll_en(main_pll_en),
    .main_div(main_div), .main_div_en(main_div_en), .main_mul(main_mul),
    .main_factor(main_factor), .main_range(main_range),
    .aux_pll_en(aux_pll_en), .aux_bias_en(aux_bias_en),
    .lock_main(lock_main), .lock_aux(lock_aux)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic slow_wait(input int n);
    for (int i = 0; i < n; i++) @(posedge sclk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] main_word(input int dv, input int ml, input int cn, input int rg);
    return (32'(rg) << 24) | (32'(cn) << 16) | (32'(ml) << 8) | 32'(dv);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 main cfg", d, 0);
    rd(3'd1, d); chk("R1 aux cfg", d, 0);
    rd(3'd2, d); chk("R1 status", d, 0);
    rd(3'd5, d); chk("R1 mask", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 div_en", main_div_en, 0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(3'd0, main_word(8'h23, 8'h04, 6'd5, 2'd2));
    rd(3'd0, d); chk("R2 readback", d, main_word(8'h23, 8'h04, 6'd5, 2'd2));
    chk("R2 div out", main_div, 8'h23);
    chk("R2 range out", main_range, 2);
    chk("R3 factor", main_factor, 5);
    chk("R3 enabled", main_pll_en, 1);
    chk("R3 div_en", main_div_en, 1);
  endtask

  task automatic t_main_lock;
    logic [31:0] d;
    // write above used count 5
    for (int i = 0; i < 5; i++) @(posedge sclk);
    @(negedge clk);
    chk("R4 still unlocked after N", lock_main, 0);
    slow_wait(8);
    chk("R4 locked by N+8", lock_main, 1);
    rd(3'd2, d); chk("R10 status bit0", d, 1);
  endtask

  task automatic t_status_ro;
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R10 status write ignored", d, 1);
    chk("R10 main cfg unchanged", main_mul, 8'h04);
  endtask

  task automatic t_drop;
    wr(3'd0, main_word(8'h00, 8'h09, 6'd6, 2'd0));
    chk("R5 lock drops next cycle", lock_main, 0);
    chk("R3 div off", main_div_en, 0);
    chk("R3 factor 10", main_factor, 10);
    for (int i = 0; i < 6; i++) @(posedge sclk);
    @(negedge clk);
    chk("R5 low through new count", lock_main, 0);
    slow_wait(8);
    chk("R5 relocks", lock_main, 1);
  endtask

  task automatic t_off;
    wr(3'd0, main_word(8'h01, 8'h00, 6'd0, 2'd0));
    slow_wait(10);
    chk("R6 mul0 lock low", lock_main, 0);
    chk("R3 mul0 disabled", main_pll_en, 0);
    chk("R3 mul0 factor", main_factor, 0);
  endtask

  task automatic t_zero;
    wr(3'd0, main_word(8'h00, 8'h01, 6'd0, 2'd1));
    slow_wait(5);
    chk("R9 count0 lock", lock_main, 1);
  endtask

  task automatic t_aux;
    logic [31:0] d;
    wr(3'd1, 32'h0000_0001);
    chk("R7 enable without bias", aux_pll_en, 0);
    slow_wait(10);
    chk("R6 aux disabled lock low", lock_aux, 0);
    wr(3'd1, 32'h0000_0303);
    chk("R7 enabled", aux_pll_en, 1);
    chk("R7 bias", aux_bias_en, 1);
    rd(3'd1, d); chk("R7 readback", d, 32'h0303);
    for (int i = 0; i < 3; i++) @(posedge sclk);
    @(negedge clk);
    chk("R7 unlocked before count", lock_aux, 0);
    slow_wait(8);
    chk("R7 locked", lock_aux, 1);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    // main locked (count 0), aux locked; disable aux first
    wr(3'd1, 32'h0);
    chk("R6 aux off drops", lock_aux, 0);
    wr(3'd3, 32'h2);
    rd(3'd5, d); chk("R8 mask aux", d, 2);
    chk("R8 irq masked channel not locked", irq, 0);
    wr(3'd3, 32'h1);
    rd(3'd5, d); chk("R8 mask both", d, 3);
    chk("R8 irq main", irq, 1);
    wr(3'd4, 32'h1);
    rd(3'd5, d); chk("R8 mask cleared", d, 2);
    chk("R8 irq off", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_fields;
    t_main_lock;
    t_status_ro;
    t_drop;
    t_off;
    t_zero;
    t_aux;
    t_irq;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule